// File: doc/BRIEF.md
# Compare-Output Waveform Timer

An 8-bit up/down timer with a single compare value and a single waveform output. A two-bit mode selects free-running counting, clear-on-compare counting, single-slope (fast) PWM or dual-slope (phase-correct) PWM. A two-bit output-action code sets what the waveform pin does on a compare match, at the bottom of the count and at the top. The meaning of that code depends on the mode. A three-bit rate code either stops the counter or advances it on ticks taken from a free-running 10-bit prescaler.

Software reaches the block through one write port. A two-bit select chooses the target: the control word, the compare value, or the flag-clear word. The block raises two sticky flags, overflow and compare match. Each flag is cleared by writing a one to its bit. In the PWM modes, a new compare value is held in a buffer until the count reaches TOP, so a duty-cycle change never produces a glitch part-way through a period.

Top module: `cmp_wave_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the waveform register is 0, the output is not driven (`drive_o` = 0), both flags are 0, the mode is free-running, the action code is 00 and the timer is stopped.
- R2: Rate code in control bits [6:4]: 000 stops the count. 001 advances it every clock. 010, 011, 100, 101, 110 and 111 advance it when the low 3, 5, 6, 7, 8 and 10 bits of a free-running prescaler (reset to 0, +1 per clock) are all ones.
- R3: Mode in control bits [1:0]. In 00 (free-running) and 11 (fast PWM) the count wraps from 0xFF to 0. In 10 (clear-on-compare) the count goes to 0 on the tick after it equals the active compare value. In 01 (phase-correct) the count runs 0 up to 0xFF and back down to 0, turning at each end.
- R4: Action code in control bits [3:2]. Code 00 in every mode, and code 01 in either PWM mode, leave `drive_o` low and hold the waveform register.
- R5: In modes 00 and 10, on a compare-match tick, action code 01 toggles the waveform, 10 clears it and 11 sets it.
- R6: In fast PWM, action code 10 clears the waveform on a match and sets it on the 0xFF-to-0 wrap. Action code 11 does the reverse.
- R7: In phase-correct PWM, action code 10 clears the waveform on a match while the count is rising and sets it on a match while falling. Action code 11 does the reverse. A match at 0 counts as rising.
- R8: If the active compare value is 0xFF and action bit 3 is 1, the match is ignored. In fast PWM the bottom action alone applies. In phase-correct PWM the waveform takes the falling-match level at the top turn.
- R9: A compare write (select 01) takes effect on the next clock in modes 00 and 10. In the PWM modes it is buffered and becomes active on the tick where the count is 0xFF.
- R10: The overflow flag is set on the 0xFF-to-0 wrap in modes 00, 10 and 11, and on the turn at 0 in phase-correct mode.
- R11: The compare flag is set on every match tick. Writing select 10 with bit 0 or bit 1 set clears the overflow or compare flag. A set in the same cycle wins over the clear.
- R12: A write with select 11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 00 control, 01 compare, 10 flag clear, 11 none |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current count |
| wave_o | output | 1 | Waveform register |
| drive_o | output | 1 | High when the waveform logic owns the pin |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The bench concentrates on the corner cases around TOP and around mode-dependent code reuse. A compare value of 0xFF with an action code in either PWM mode is one target; a design that did not ignore that match would let the pin glitch once per period instead of holding steady. The phase-correct turn points are another: a wrong direction flag on the match at 0 or at 0xFF would invert the pulse. Writes to the compare value made mid-period in fast PWM are also exercised; an unbuffered design would raise the compare flag at the new value one period early. Code 01 is applied in the PWM modes, where a design that toggled as in the non-PWM modes would drive the pin when it must leave it alone.

// File: rtl/cwt_pkg.sv
// Shared types for the compare-output waveform timer.
// Assumes an 8-bit count; the mode encoding is visible to software.
package cwt_pkg;
    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_PHASE = 2'b01,
        MODE_CTC   = 2'b10,
        MODE_FAST  = 2'b11
    } mode_e;

    localparam logic [1:0] SEL_CTRL = 2'b00;
    localparam logic [1:0] SEL_CMP  = 2'b01;
    localparam logic [1:0] SEL_CLR  = 2'b10;
endpackage

// File: rtl/cwt_prescaler.sv
// Free-running prescaler and tick selector.
// Produces a one-clock tick at the rate picked by rate_sel.
// Assumes PRE_W is at least 10 so that the slowest rate fits.
module cwt_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] low_mask;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Pick how many low bits must be all ones for a tick.
    always_comb begin
        case (rate_sel)
            3'd2:    low_mask = PRE_W'((1 << 3) - 1);
            3'd3:    low_mask = PRE_W'((1 << 5) - 1);
            3'd4:    low_mask = PRE_W'((1 << 6) - 1);
            3'd5:    low_mask = PRE_W'((1 << 7) - 1);
            3'd6:    low_mask = PRE_W'((1 << 8) - 1);
            3'd7:    low_mask = PRE_W'((1 << 10) - 1);
            default: low_mask = '0;
        endcase
        tick = (rate_sel != 3'd0) && ((pre_q & low_mask) == low_mask);
    end

    // R2
    div8_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rate_sel == 3'd2 && $past(rate_sel) == 3'd2) |-> !$past(tick));
endmodule

// File: rtl/cwt_counter.sv
// Counting engine: free-running, clear-on-compare, fast and dual-slope.
// Emits match, wrap, top and overflow events qualified by the tick.
// Assumes the compare value given is the active (not buffered) one.
module cwt_counter #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  cwt_pkg::mode_e    mode,
    input  logic [CNT_W-1:0]  cmp_act,
    output logic [CNT_W-1:0]  cnt,
    output logic              step_up,
    output logic              match_evt,
    output logic              wrap_evt,
    output logic              top_evt,
    output logic              ovf_evt
);
    import cwt_pkg::*;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic             rising_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             is_max;
    logic             is_zero;

    // Event and next-count decode.
    always_comb begin
        is_max    = (cnt == MAXV);
        is_zero   = (cnt == '0);
        match_evt = tick && (cnt == cmp_act);
        step_up   = (mode == MODE_PHASE) ? ((rising_q && !is_max) || (!rising_q && is_zero)) : 1'b1;
        wrap_evt  = tick && is_max && (mode != MODE_PHASE);
        top_evt   = tick && is_max && ((mode == MODE_PHASE) || (mode == MODE_FAST));
        ovf_evt   = (mode == MODE_PHASE) ? (tick && is_zero && !rising_q) : wrap_evt;
        case (mode)
            MODE_CTC:   cnt_nxt = (cnt == cmp_act) ? '0 : cnt + 1'b1;
            MODE_PHASE: cnt_nxt = step_up ? cnt + 1'b1 : cnt - 1'b1;
            default:    cnt_nxt = cnt + 1'b1;
        endcase
    end

    // Count register, advanced only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt_nxt;
    end

    // Direction register; forced rising outside dual-slope mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rising_q <= 1'b1;
        else if (mode != MODE_PHASE) rising_q <= 1'b1;
        else if (tick)               rising_q <= step_up;
    end

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && is_max && (mode == MODE_FREE || mode == MODE_FAST)) |=> (cnt == '0));
    // R3
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_CTC && cnt == cmp_act) |=> (cnt == '0));
    // R3
    phase_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_PHASE && is_max) |=> (cnt == MAXV - 1'b1 && !rising_q));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/cwt_waveform.sv
// Waveform generator: reads the action code against the mode and
// updates the output register on match, wrap and top events.
// Assumes all events arrive already qualified by the tick.
module cwt_waveform #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cwt_pkg::mode_e    mode,
    input  logic [1:0]        act_code,
    input  logic [CNT_W-1:0]  cmp_act,
    input  logic              step_up,
    input  logic              match_evt,
    input  logic              wrap_evt,
    input  logic              top_evt,
    output logic              wave,
    output logic              drive
);
    import cwt_pkg::*;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic pwm;
    logic at_top_case;
    logic wave_nxt;

    // Decode the action for this cycle.
    always_comb begin
        pwm         = (mode == MODE_FAST) || (mode == MODE_PHASE);
        drive       = (act_code != 2'b00) && !(pwm && act_code == 2'b01);
        at_top_case = act_code[1] && (cmp_act == MAXV);
        wave_nxt    = wave;
        case (mode)
            MODE_FREE, MODE_CTC: begin
                if (match_evt) begin
                    case (act_code)
                        2'b01:   wave_nxt = ~wave;
                        2'b10:   wave_nxt = 1'b0;
                        2'b11:   wave_nxt = 1'b1;
                        default: wave_nxt = wave;
                    endcase
                end
            end
            MODE_FAST: begin
                if (act_code[1]) begin
                    if (wrap_evt)       wave_nxt = ~act_code[0];
                    else if (match_evt) wave_nxt = act_code[0];
                end
            end
            default: begin
                if (act_code[1]) begin
                    if (at_top_case) begin
                        if (top_evt) wave_nxt = ~act_code[0];
                    end else if (match_evt) begin
                        wave_nxt = step_up ? act_code[0] : ~act_code[0];
                    end
                end
            end
        endcase
    end

    // Waveform register.
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= wave_nxt;
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> $stable(wave));
    // R6
    fast_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAST && act_code == 2'b10 && wrap_evt) |=> wave);
    // R8
    phase_top_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PHASE && act_code[1] && cmp_act == MAXV && !top_evt) |=> $stable(wave));
endmodule

// File: rtl/cmp_wave_timer.sv
// Top level: write-port decode, compare buffering, sticky flags, and
// the prescaler, counter and waveform sub-blocks.
// Assumes one write per clock at most; the select picks the target.
module cmp_wave_timer #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             wave_o,
    output logic             drive_o,
    output logic             ovf_flag_o,
    output logic             cmp_flag_o
);
    import cwt_pkg::*;

    mode_e            mode_q;
    logic [1:0]       act_q;
    logic [2:0]       rate_q;
    logic [CNT_W-1:0] cmp_buf_q;
    logic [CNT_W-1:0] cmp_act_q;
    logic             tick;
    logic             step_up;
    logic             match_evt;
    logic             wrap_evt;
    logic             top_evt;
    logic             ovf_evt;
    logic             pwm;
    logic             wr_ctrl;
    logic             wr_cmp;
    logic             wr_clr;

    // Write-port decode.
    always_comb begin
        pwm     = (mode_q == MODE_FAST) || (mode_q == MODE_PHASE);
        wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
        wr_cmp  = wr_en && (wr_sel == SEL_CMP);
        wr_clr  = wr_en && (wr_sel == SEL_CLR);
    end

    // Control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FREE;
            act_q  <= 2'b00;
            rate_q <= 3'd0;
        end else if (wr_ctrl) begin
            mode_q <= mode_e'(wr_data[1:0]);
            act_q  <= wr_data[3:2];
            rate_q <= wr_data[6:4];
        end
    end

    // Compare buffer and active compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buf_q <= '0;
            cmp_act_q <= '0;
        end else begin
            if (wr_cmp) cmp_buf_q <= wr_data;
            if (wr_cmp && !pwm)      cmp_act_q <= wr_data;
            else if (pwm && top_evt) cmp_act_q <= cmp_buf_q;
        end
    end

    // Sticky flags; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag_o <= 1'b0;
            cmp_flag_o <= 1'b0;
        end else begin
            if (ovf_evt)                  ovf_flag_o <= 1'b1;
            else if (wr_clr && wr_data[0]) ovf_flag_o <= 1'b0;
            if (match_evt)                cmp_flag_o <= 1'b1;
            else if (wr_clr && wr_data[1]) cmp_flag_o <= 1'b0;
        end
    end

    cwt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_q), .tick(tick)
    );

    cwt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .cmp_act(cmp_act_q),
        .cnt(count_o), .step_up(step_up), .match_evt(match_evt), .wrap_evt(wrap_evt),
        .top_evt(top_evt), .ovf_evt(ovf_evt)
    );

    cwt_waveform #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .act_code(act_q), .cmp_act(cmp_act_q),
        .step_up(step_up), .match_evt(match_evt), .wrap_evt(wrap_evt), .top_evt(top_evt),
        .wave(wave_o), .drive(drive_o)
    );

    // R11
    cmp_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> cmp_flag_o);
    // R10
    ovf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag_o);
    // R9
    cmp_buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !top_evt) |=> $stable(cmp_act_q));
    // R12
    null_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11) |=> ($stable(mode_q) && $stable(cmp_buf_q)));
endmodule

// File: tb/cmp_wave_timer_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module cmp_wave_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] count_o;
    logic       wave_o, drive_o, ovf_flag_o, cmp_flag_o;

    int tests = 0;
    int fails = 0;
    bit compare_on = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cmp_wave_timer u_cmp_wave_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count_o(count_o), .wave_o(wave_o), .drive_o(drive_o),
        .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o)
    );

    // Reference model state.
    int m_pre, m_cnt, m_mode, m_act, m_rate, m_buf, m_cmp;
    bit m_up, m_wave, m_ovf, m_cf;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit m_pwm();
        return (m_mode == 1) || (m_mode == 3);
    endfunction

    // Model advance on each clock.
    always @(posedge clk) begin
        int sh, ncnt;
        bit tick, hit, ovf_e, top, nup, nwave, dir;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_mode = 0; m_act = 0; m_rate = 0;
            m_buf = 0; m_cmp = 0; m_up = 1; m_wave = 0; m_ovf = 0; m_cf = 0;
        end else begin
            case (m_rate)
                2: sh = 3; 3: sh = 5; 4: sh = 6; 5: sh = 7; 6: sh = 8; 7: sh = 10;
                default: sh = 0;
            endcase
            tick = (m_rate != 0) && ((m_pre % (1 << sh)) == ((1 << sh) - 1));
            hit = tick && (m_cnt == m_cmp);
            ovf_e = 0; ncnt = m_cnt; nup = 1; dir = 1; nwave = m_wave;
            top = tick && m_cnt == 255 && m_pwm();
            if (m_mode == 1) begin
                nup = m_up;
                if (tick) begin
                    if (m_up) begin
                        if (m_cnt == 255) begin ncnt = 254; nup = 0; dir = 0; end
                        else ncnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin ncnt = 1; nup = 1; ovf_e = 1; end
                        else begin ncnt = m_cnt - 1; dir = 0; end
                    end
                end
            end else if (tick) begin
                ovf_e = (m_cnt == 255);
                if (m_mode == 2 && hit) ncnt = 0;
                else ncnt = (m_cnt + 1) % 256;
            end
            // Waveform behaviour by mode.
            if (m_mode == 0 || m_mode == 2) begin
                if (hit && m_act == 1) nwave = !m_wave;
                if (hit && m_act == 2) nwave = 0;
                if (hit && m_act == 3) nwave = 1;
            end else if (m_mode == 3 && m_act >= 2) begin
                if (tick && m_cnt == 255) nwave = (m_act == 2);
                else if (hit) nwave = (m_act == 3);
            end else if (m_mode == 1 && m_act >= 2) begin
                if (m_cmp == 255) begin
                    if (top) nwave = (m_act == 2);
                end else if (hit) begin
                    nwave = dir ? (m_act == 3) : (m_act == 2);
                end
            end
            if (wr_en && wr_sel == 1 && !m_pwm()) m_cmp = wr_data;
            else if (top) m_cmp = m_buf;
            if (wr_en && wr_sel == 1) m_buf = wr_data;
            if (ovf_e) m_ovf = 1; else if (wr_en && wr_sel == 2 && wr_data[0]) m_ovf = 0;
            if (hit) m_cf = 1; else if (wr_en && wr_sel == 2 && wr_data[1]) m_cf = 0;
            m_cnt = ncnt; m_up = nup; m_wave = nwave;
            if (wr_en && wr_sel == 0) begin
                m_mode = wr_data[1:0]; m_act = wr_data[3:2]; m_rate = wr_data[6:4];
            end
            m_pre = (m_pre + 1) % 1024;
        end
    end

    // Compare design against model every cycle.
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            chk("R3 count", count_o, m_cnt);
            chk("R4 drive", drive_o, (m_act != 0) && !(m_pwm() && m_act == 1));
            if (m_mode == 3)      chk("R6 wave", wave_o, m_wave);
            else if (m_mode == 1) chk("R7 wave", wave_o, m_wave);
            else                  chk("R5 wave", wave_o, m_wave);
            chk("R10 ovf flag", ovf_flag_o, m_ovf);
            chk("R11 cmp flag", cmp_flag_o, m_cf);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ctl(input int mode, input int act, input int rate);
        return {1'b0, 3'(rate), 2'(act), 2'(mode)};
    endfunction

    initial begin
        logic [7:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 wave", wave_o, 0);
        chk("R1 drive", drive_o, 0);
        chk("R1 ovf", ovf_flag_o, 0);
        chk("R1 cmp", cmp_flag_o, 0);
        run(20);
        chk("R1 stopped", count_o, 0);
        compare_on = 1'b1;

        // R9: buffered compare in fast PWM
        wr(2'b00, ctl(3, 0, 0));
        wr(2'b01, 8'h05);
        wr(2'b00, ctl(3, 0, 1));
        run(2);
        chk("R9 old value active", cmp_flag_o, 1);
        wr(2'b10, 8'h03);
        chk("R11 clear by one", cmp_flag_o, 0);
        run(100);
        chk("R9 new value not yet active", cmp_flag_o, 0);
        run(300);
        chk("R9 new value after top", cmp_flag_o, 1);
        chk("R10 overflow seen", ovf_flag_o, 1);

        // R2 stop and R12 null write
        wr(2'b00, ctl(3, 0, 0));
        held = count_o;
        wr(2'b11, 8'h5F);
        run(40);
        chk("R2 stopped count", count_o, held);
        chk("R12 null write", drive_o, 0);

        // R5 non-PWM actions
        wr(2'b00, ctl(0, 1, 1)); wr(2'b01, 8'h40); run(600);
        wr(2'b00, ctl(0, 2, 1)); run(300);
        wr(2'b00, ctl(0, 3, 1)); run(300);
        wr(2'b00, ctl(2, 1, 1)); wr(2'b01, 8'h30); run(400);
        wr(2'b00, ctl(2, 2, 2)); run(2000);
        wr(2'b00, ctl(2, 1, 3)); run(3000);
        wr(2'b00, ctl(0, 1, 4)); run(2000);

        // R6 fast PWM, R4 reserved code
        wr(2'b00, ctl(3, 2, 1)); wr(2'b01, 8'h80); run(600);
        wr(2'b00, ctl(3, 3, 1)); run(600);
        wr(2'b00, ctl(3, 1, 1)); run(300);
        chk("R4 reserved code undriven", drive_o, 0);

        // R8 fast PWM with compare at top
        wr(2'b00, ctl(3, 2, 1)); wr(2'b01, 8'hFF); run(600);
        chk("R8 fast top non-inverting", wave_o, 1);
        wr(2'b00, ctl(3, 3, 1)); run(600);
        chk("R8 fast top inverting", wave_o, 0);

        // R7 phase-correct PWM
        wr(2'b00, ctl(1, 2, 1)); wr(2'b01, 8'h60); run(1200);
        wr(2'b00, ctl(1, 3, 1)); run(1200);
        wr(2'b00, ctl(1, 2, 1)); wr(2'b01, 8'hFF); run(1200);
        chk("R8 phase top non-inverting", wave_o, 1);
        wr(2'b00, ctl(1, 3, 1)); run(1200);
        chk("R8 phase top inverting", wave_o, 0);
        wr(2'b00, ctl(1, 2, 1)); wr(2'b01, 8'h00); run(1200);
        wr(2'b00, ctl(1, 2, 5)); wr(2'b01, 8'h20); run(3000);

        // R11 clear while running, including same-cycle set
        wr(2'b00, ctl(0, 1, 1)); wr(2'b01, 8'h10);
        repeat (20) begin
            wr(2'b10, 8'h03);
            run(7);
        end
        run(10);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule